// File: doc/BRIEF.md
# Radar Chirp Timing Controller

This block sets the timing of transmit chirps for a pulsed radar front end. It runs in one clock domain. A chirp starts when a request strobe arrives while the global mixer enable is high. The 2-bit waveform select is captured at that moment and fixes the chirp length: short, medium or long. For that many cycles the block:

- holds chirp-valid and the RF switch high;
- gives the mixers to the transmit side;
- counts samples and drives a placeholder sample byte.

On the last sample it gives a one-cycle done pulse and bumps a 6-bit chirp counter. Outside a chirp the mixers belong to the receive side.

A frame pulse clears the chirp counter and sends the sequencer back to idle. A chirp in flight ends without being counted. Dropping the global mixer enable turns both mixer enables off in the same cycle and also sends the sequencer to idle. The beamformer load outputs exist only so the pin list is complete, and they are held low.

Top module: `chirp_timing_ctrl`

## Requirements
- R1: The chirp length in cycles comes from `wave_sel` captured at the start: 2'b00 gives 120, 2'b01 gives 600, 2'b10 gives 3600, and the reserved code 2'b11 gives 120.
- R2: `chirp_count` is 0 after reset. It rises by one on the clock edge that ends each completed chirp, and wraps from 63 to 0.
- R3: A frame pulse clears `chirp_count` to 0 at the next edge and ends any chirp at that edge. It takes priority over a start request or a chirp completion in the same cycle: no done pulse and no count.
- R4: `tx_mix_en` is high only while a chirp runs with `mix_en` high. `rx_mix_en` is high while `mix_en` is high and no chirp runs. The two are never high together.
- R5: While `mix_en` is low, both mixer enables are low in that same cycle and `chirp_done` is low. The sequencer is idle after the next edge, and an aborted chirp is not counted.
- R6: After reset, `chirp_valid`, `rf_switch`, `chirp_done` and `chirp_count` are all zero.
- R7: `chirp_valid` and `rf_switch` are high for exactly the chirp length of R1, starting the cycle after the accepted request.
- R8: `chirp_done` is a single-cycle pulse in the last cycle in which `chirp_valid` is high.
- R9: A chirp starts only from idle, when `chirp_req` is high with `mix_en` high and no frame pulse. A request during a chirp is ignored, and changes on `wave_sel` during a chirp do not change its length.
- R10: Every bit of `bf_tx_load` and `bf_rx_load` is always 0.
- R11: During a chirp, `sample_byte` equals the sample index within the chirp, counted from 0, modulo 256. Outside a chirp it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chirp clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mix_en | input | 1 | Global mixer enable |
| chirp_req | input | 1 | Chirp start request strobe |
| wave_sel | input | 2 | Waveform length select |
| frame_pulse | input | 1 | Frame boundary: clears counter, ends chirp |
| chirp_valid | output | 1 | High while a chirp runs |
| sample_byte | output | 8 | Placeholder sample value |
| rf_switch | output | 1 | RF switch to transmit path |
| tx_mix_en | output | 1 | Transmit mixer enable |
| rx_mix_en | output | 1 | Receive mixer enable |
| chirp_done | output | 1 | One-cycle pulse on the last chirp sample |
| chirp_count | output | 6 | Completed-chirp counter |
| bf_tx_load | output | 4 | Beamformer transmit load pins, held low |
| bf_rx_load | output | 4 | Beamformer receive load pins, held low |

## Verification
The properties assume that `mix_en`, `chirp_req`, `wave_sel` and `frame_pulse` are synchronous to `clk` and never unknown once reset is released. The sequencer properties also assume that a frame pulse may coincide with any state, including the last sample of a chirp. The bench changes every input only on the falling edge. Its random stimulus draws lengths, select codes and idle gaps from a fixed seed. On top of that it places directed requests mid-chirp, select changes mid-chirp, a frame pulse on the final sample, and mixer-enable drops inside a chirp.

// File: rtl/chirp_tmr_pkg.sv
package chirp_tmr_pkg;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_CHIRP = 1'b1
   } tmr_state_t;

   typedef enum logic [1:0] {
      WV_SHORT  = 2'd0,
      WV_MEDIUM = 2'd1,
      WV_LONG   = 2'd2,
      WV_RSVD   = 2'd3
   } wave_t;

   // Chirp length for a select code; the reserved code falls back to short.
   function automatic int unsigned wave_len(input logic [1:0] sel,
                                            input int unsigned len_s,
                                            input int unsigned len_m,
                                            input int unsigned len_l);
      case (sel)
         WV_MEDIUM: return len_m;
         WV_LONG:   return len_l;
         default:   return len_s;
      endcase
   endfunction

endpackage

// File: rtl/chirp_tmr_seq.sv
module chirp_tmr_seq
   import chirp_tmr_pkg::*;
#(
   parameter int unsigned SHORT_LEN = 120,
   parameter int unsigned MED_LEN   = 600,
   parameter int unsigned LONG_LEN  = 3600,
   parameter int unsigned SMP_W     = 12
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mix_en,
   input  logic             req,
   input  logic [1:0]       sel,
   input  logic             frame,
   output logic             in_chirp,
   output logic             done,
   output logic [SMP_W-1:0] smp
);

   tmr_state_t       state;
   logic [SMP_W-1:0] last_idx;
   logic             at_last;

   assign in_chirp = (state == ST_CHIRP);
   assign at_last  = in_chirp && (smp == last_idx);
   assign done     = at_last && mix_en && !frame;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         smp      <= '0;
         last_idx <= '0;
      end else if (!mix_en || frame) begin
         state <= ST_IDLE;
         smp   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (req) begin
                  state    <= ST_CHIRP;
                  smp      <= '0;
                  last_idx <= SMP_W'(wave_len(sel, SHORT_LEN, MED_LEN, LONG_LEN) - 1);
               end
            end
            ST_CHIRP: begin
               if (at_last) begin
                  state <= ST_IDLE;
                  smp   <= '0;
               end else begin
                  smp <= smp + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R9: entry into a chirp must be caused by an accepted request
   a_r9_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_chirp) |-> $past(req && mix_en && !frame));
   // R9: captured length does not move while the chirp runs
   a_r9_len_held: assert property (@(posedge clk) disable iff (!rst_n)
      (in_chirp && $past(in_chirp)) |-> $stable(last_idx));
   // R1: sample index never passes the captured last index
   a_r1_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      in_chirp |-> (smp <= last_idx));
   // R5: mixer disable sends the sequencer to idle
   a_r5_mix_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !mix_en |=> !in_chirp);
   // R3: frame pulse ends the chirp
   a_r3_frame_ends: assert property (@(posedge clk) disable iff (!rst_n)
      frame |=> !in_chirp);
   // R8: done never lasts two cycles
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/chirp_tmr_count.sv
module chirp_tmr_count #(
   parameter int unsigned CNT_W = 6
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame,
   input  logic             done,
   output logic [CNT_W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (frame)  cnt <= '0;
      else if (done)   cnt <= cnt + 1'b1;
   end

   // R3: frame pulse clears the counter
   a_r3_frame_clear: assert property (@(posedge clk) disable iff (!rst_n)
      frame |=> (cnt == '0));
   // R2: one step per completed chirp, wrapping at the top
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !frame) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
   // R2: otherwise the counter holds
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && !frame) |=> $stable(cnt));

endmodule

// File: rtl/chirp_tmr_drive.sv
module chirp_tmr_drive #(
   parameter int unsigned N_BF   = 4,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SMP_W  = 12
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mix_en,
   input  logic              in_chirp,
   input  logic [SMP_W-1:0]  smp,
   output logic              valid,
   output logic              rf_sw,
   output logic              tx_en,
   output logic              rx_en,
   output logic [DATA_W-1:0] data,
   output logic [N_BF-1:0]   tx_load,
   output logic [N_BF-1:0]   rx_load
);

   assign valid = in_chirp;
   assign rf_sw = in_chirp;
   assign tx_en = mix_en &&  in_chirp;
   assign rx_en = mix_en && !in_chirp;

   generate
      if (DATA_W <= SMP_W) begin : g_data_trunc
         assign data = in_chirp ? DATA_W'(smp) : '0;
      end else begin : g_data_ext
         assign data = in_chirp ? {{(DATA_W-SMP_W){1'b0}}, smp} : '0;
      end
   endgenerate

   generate
      for (genvar g = 0; g < N_BF; g++) begin : g_bf
         assign tx_load[g] = 1'b0;
         assign rx_load[g] = 1'b0;
      end
   endgenerate

   // R4: the mixer enables are mutually exclusive
   a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_en && rx_en));
   // R5: with mixers disabled, neither side is enabled
   a_r5_both_off: assert property (@(posedge clk) disable iff (!rst_n)
      !mix_en |-> (!tx_en && !rx_en));

endmodule

// File: rtl/chirp_timing_ctrl.sv
module chirp_timing_ctrl #(
   parameter int unsigned SHORT_LEN = 120,
   parameter int unsigned MED_LEN   = 600,
   parameter int unsigned LONG_LEN  = 3600,
   parameter int unsigned CNT_W     = 6,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned N_BF      = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mix_en,
   input  logic              chirp_req,
   input  logic [1:0]        wave_sel,
   input  logic              frame_pulse,
   output logic              chirp_valid,
   output logic [DATA_W-1:0] sample_byte,
   output logic              rf_switch,
   output logic              tx_mix_en,
   output logic              rx_mix_en,
   output logic              chirp_done,
   output logic [CNT_W-1:0]  chirp_count,
   output logic [N_BF-1:0]   bf_tx_load,
   output logic [N_BF-1:0]   bf_rx_load
);

   localparam int unsigned SMP_W = $clog2(LONG_LEN);

   generate
      if (!(SHORT_LEN > 0 && SHORT_LEN <= MED_LEN && MED_LEN <= LONG_LEN && LONG_LEN > 1))
      begin : g_bad_len
         $error("chirp_timing_ctrl: lengths must satisfy 0 < short <= medium <= long, long > 1");
      end
      if (CNT_W < 1 || DATA_W < 1 || N_BF < 1) begin : g_bad_width
         $error("chirp_timing_ctrl: counter, data and load widths must be at least 1");
      end
   endgenerate

   logic             in_chirp;
   logic             done;
   logic [SMP_W-1:0] smp;

   chirp_tmr_seq #(
      .SHORT_LEN (SHORT_LEN),
      .MED_LEN   (MED_LEN),
      .LONG_LEN  (LONG_LEN),
      .SMP_W     (SMP_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .mix_en   (mix_en),
      .req      (chirp_req),
      .sel      (wave_sel),
      .frame    (frame_pulse),
      .in_chirp (in_chirp),
      .done     (done),
      .smp      (smp)
   );

   chirp_tmr_count #(
      .CNT_W (CNT_W)
   ) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .frame (frame_pulse),
      .done  (done),
      .cnt   (chirp_count)
   );

   chirp_tmr_drive #(
      .N_BF   (N_BF),
      .DATA_W (DATA_W),
      .SMP_W  (SMP_W)
   ) u_drive (
      .clk      (clk),
      .rst_n    (rst_n),
      .mix_en   (mix_en),
      .in_chirp (in_chirp),
      .smp      (smp),
      .valid    (chirp_valid),
      .rf_sw    (rf_switch),
      .tx_en    (tx_mix_en),
      .rx_en    (rx_mix_en),
      .data     (sample_byte),
      .tx_load  (bf_tx_load),
      .rx_load  (bf_rx_load)
   );

   assign chirp_done = done;

   // R8: done only occurs inside a chirp, with the mixers enabled
   a_r8_done_in_chirp: assert property (@(posedge clk) disable iff (!rst_n)
      chirp_done |-> (chirp_valid && tx_mix_en));

endmodule

// File: tb/tb_chirp_timing_ctrl.sv
`timescale 1ns/1ps
module tb_chirp_timing_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mix_en = 1'b0;
   logic       chirp_req = 1'b0;
   logic [1:0] wave_sel = 2'd0;
   logic       frame_pulse = 1'b0;
   logic       chirp_valid, rf_switch, tx_mix_en, rx_mix_en, chirp_done;
   logic [7:0] sample_byte;
   logic [5:0] chirp_count;
   logic [3:0] bf_tx_load, bf_rx_load;

   int checks = 0;
   int errors = 0;
   int exp_cnt = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   chirp_timing_ctrl dut (
      .clk(clk), .rst_n(rst_n), .mix_en(mix_en), .chirp_req(chirp_req),
      .wave_sel(wave_sel), .frame_pulse(frame_pulse),
      .chirp_valid(chirp_valid), .sample_byte(sample_byte),
      .rf_switch(rf_switch), .tx_mix_en(tx_mix_en), .rx_mix_en(rx_mix_en),
      .chirp_done(chirp_done), .chirp_count(chirp_count),
      .bf_tx_load(bf_tx_load), .bf_rx_load(bf_rx_load)
   );

   function automatic int exp_len(input logic [1:0] s);
      case (s)
         2'd1:    return 600;
         2'd2:    return 3600;
         default: return 120;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Start a chirp and follow it to its end; check length, done, count, data.
   task automatic run_chirp(input logic [1:0] sel, input bit poke);
      int n = 0, done_n = 0, done_at = -1, bad_data = 0, bad_mix = 0;
      @(negedge clk);
      wave_sel = sel; chirp_req = 1'b1;
      @(negedge clk);
      chirp_req = 1'b0;
      if (poke) wave_sel = ~sel;                 // R9: must not change length
      while (chirp_valid === 1'b1 && n < 5000) begin
         if (sample_byte !== 8'(n)) bad_data++;
         if (tx_mix_en !== 1'b1 || rx_mix_en !== 1'b0 || rf_switch !== 1'b1) bad_mix++;
         if (chirp_done === 1'b1) begin done_n++; done_at = n; end
         n++;
         @(negedge clk);
         if (poke) chirp_req = (n == 5);         // R9: request mid-chirp ignored
      end
      chirp_req = 1'b0;
      exp_cnt = (exp_cnt + 1) % 64;
      chk(n == exp_len(sel), "R1/R7", "chirp length", n, exp_len(sel));
      chk(done_n == 1 && done_at == n - 1, "R8", "done position", done_at, n - 1);
      chk(chirp_count == 6'(exp_cnt), "R2", "count after chirp", chirp_count, exp_cnt);
      chk(bad_data == 0, "R11", "sample byte mismatches", bad_data, 0);
      chk(bad_mix == 0 && rx_mix_en && !tx_mix_en && !chirp_done && sample_byte == 0,
          "R4", "mixer mismatches", bad_mix, 0);
      chk(bf_tx_load == 0 && bf_rx_load == 0, "R10", "load pins",
          {bf_tx_load, bf_rx_load}, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int seed = $urandom(32'h00C0FFEE);
      idle(3);
      // R6 reset state
      chk(!chirp_valid && !rf_switch && !chirp_done, "R6", "flags in reset",
          {chirp_valid, rf_switch, chirp_done}, 0);
      chk(chirp_count == 0, "R6", "count in reset", chirp_count, 0);
      chk(bf_tx_load == 0 && bf_rx_load == 0, "R10", "load pins in reset",
          {bf_tx_load, bf_rx_load}, 0);
      rst_n = 1'b1;
      idle(2);
      chk(!tx_mix_en && !rx_mix_en, "R5", "mixers off while disabled",
          {tx_mix_en, rx_mix_en}, 0);

      // R9: request with mixers disabled is ignored
      chirp_req = 1'b1; idle(2); chirp_req = 1'b0; idle(1);
      chk(!chirp_valid && chirp_count == 0, "R9", "start without mix_en",
          chirp_valid, 0);

      mix_en = 1'b1;
      idle(1);
      chk(rx_mix_en && !tx_mix_en, "R4", "receive side when idle",
          {tx_mix_en, rx_mix_en}, 1);

      // directed: each select code, with mid-chirp pokes on one
      run_chirp(2'd0, 1'b0);
      run_chirp(2'd1, 1'b1);
      run_chirp(2'd2, 1'b0);
      run_chirp(2'd3, 1'b0);

      // R3: frame pulse mid-chirp
      @(negedge clk); wave_sel = 2'd2; chirp_req = 1'b1;
      @(negedge clk); chirp_req = 1'b0;
      idle(50);
      frame_pulse = 1'b1;
      @(negedge clk); frame_pulse = 1'b0;
      chk(!chirp_valid && chirp_count == 0, "R3", "frame mid-chirp count",
          chirp_count, 0);
      exp_cnt = 0;

      // R3: frame on the last sample wins over completion
      run_chirp(2'd0, 1'b0);
      @(negedge clk); wave_sel = 2'd0; chirp_req = 1'b1;
      @(negedge clk); chirp_req = 1'b0;
      idle(119);
      frame_pulse = 1'b1;
      #1;
      chk(chirp_valid && !chirp_done, "R3", "done suppressed on last sample",
          chirp_done, 0);
      @(negedge clk); frame_pulse = 1'b0;
      chk(!chirp_valid && chirp_count == 0, "R3", "count after last-sample frame",
          chirp_count, 0);
      exp_cnt = 0;

      // R3: frame and request together: no start
      @(negedge clk); frame_pulse = 1'b1; chirp_req = 1'b1;
      @(negedge clk); frame_pulse = 1'b0; chirp_req = 1'b0;
      chk(!chirp_valid, "R3", "request blocked by frame", chirp_valid, 0);

      // R5: mixer drop mid-chirp
      run_chirp(2'd1, 1'b0);
      @(negedge clk); wave_sel = 2'd1; chirp_req = 1'b1;
      @(negedge clk); chirp_req = 1'b0;
      idle(30);
      mix_en = 1'b0;
      #1;
      chk(!tx_mix_en && !rx_mix_en && !chirp_done, "R5", "enables off at once",
          {tx_mix_en, rx_mix_en, chirp_done}, 0);
      @(negedge clk);
      chk(!chirp_valid, "R5", "idle after disable", chirp_valid, 0);
      mix_en = 1'b1;
      idle(3);
      chk(!chirp_valid && chirp_count == 6'(exp_cnt), "R5", "aborted chirp not counted",
          chirp_count, exp_cnt);

      // R2: wrap from 63 to 0
      @(negedge clk); frame_pulse = 1'b1;
      @(negedge clk); frame_pulse = 1'b0;
      exp_cnt = 0;
      for (int i = 0; i < 64; i++) run_chirp(2'd0, 1'b0);
      chk(chirp_count == 0, "R2", "wrap to zero", chirp_count, 0);

      // constrained random: select codes, gaps, optional pokes
      for (int i = 0; i < 12; i++) begin
         idle($urandom_range(0, 9));
         run_chirp(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      end

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial if (seed_unused()) ;
   function automatic bit seed_unused();
      return 1'b0;
   endfunction

endmodule